// File: doc/BRIEF.md
# Periodic Task-Chain Power Sequencer

This block sequences a sensor node that is built from four dedicated hardware tasks instead of a processor. A free-running interval timer raises an event every `PERIOD_CYC` clock cycles. Each event starts a chain that activates the tasks one after another: sensing, processing, sending and acknowledgement reception. Each task is woken by a power enable and then receives a one-cycle start pulse. The completion line of the running task hands control to the next task in the chain. A task has supply only while it is the active link of the chain, so no more than one task is ever powered.

The sequencer also switches the node's memory supplies. The region that holds the measured value is gated. It stays powered from the moment sensing is woken until sending reports completion. The region that holds the node and neighbour identifiers is kept on at all times. An event from the radio side can start the acknowledgement task by itself while the node is idle. A timer event that arrives while a chain is running is remembered and served as soon as the chain ends.

Top module: `mtask_seq`

## Requirements
- R1: Timer events occur every `PERIOD_CYC` clock cycles. When the sequencer is idle, the chain starts in the cycle that follows the event, so successive chain starts lie exactly `PERIOD_CYC` cycles apart.
- R2: Tasks are activated in the fixed order sense (bit 0), process (bit 1), send (bit 2), acknowledge (bit 3). The next task's power bit is set in the cycle that follows the accepted completion of the previous task.
- R3: A task's power bit is set one cycle before its start bit. The start bit is a single-cycle pulse. The power bit then stays set until that task's completion is accepted.
- R4: At most one bit of `task_pwr` is set. After the acknowledgement task completes, all task power is off.
- R5: A completion is accepted only from the currently running task, and only after its start pulse. Completion lines of other tasks have no effect on power or start outputs.
- R6: `gmem_pwr` is high exactly while the sense, process or send task is powered, and low while idle or while the acknowledgement task runs.
- R7: `amem_pwr` is high at all times, including during reset.
- R8: A timer event that arrives while a chain is active is held pending. After the chain ends, the sequencer spends one idle cycle and then wakes the sensing task.
- R9: A pulse on `radio_evt` while the sequencer is idle wakes only the acknowledgement task, with the gated memory off, and the sequencer returns to idle after that task completes.
- R10: A pulse on `radio_evt` while a chain is active has no effect.
- R11: While `rst_n` is low, and right after reset is released, no task is powered or started, the gated memory is off and no pending event is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_done | input | 4 | Completion lines, one per task (bit 0 sense … bit 3 acknowledge) |
| radio_evt | input | 1 | External event from the radio that starts the acknowledgement task |
| task_pwr | output | 4 | Power enable, one per task |
| task_go | output | 4 | Single-cycle start pulse, one per task |
| gmem_pwr | output | 1 | Supply enable for the gated measurement memory |
| amem_pwr | output | 1 | Supply enable for the always-on identifier memory |

## Verification
A corrupted chain index shows up in `task_pwr` in the very next cycle: the bit is out of order, or the gated memory is wrongly off during the send stage. A state machine stuck in a wake or wait state shows as a power bit held without a start pulse, or as a chain that never returns to idle. A lost pending flag appears one cycle after a long chain ends, when the sensing task fails to wake. A timer that miscounts shifts the spacing between chain starts away from `PERIOD_CYC` on the first period.

// File: rtl/mtask_seq_pkg.sv
package mtask_seq_pkg;

  // Number of chained tasks and index width
  localparam int TASK_N  = 4;
  localparam int TASK_IW = $clog2(TASK_N);

  // Positions in the chain; the order is behaviour
  localparam logic [TASK_IW-1:0] IDX_SENSE = TASK_IW'(0);
  localparam logic [TASK_IW-1:0] IDX_SEND  = TASK_IW'(2);
  localparam logic [TASK_IW-1:0] IDX_ACK   = TASK_IW'(TASK_N - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAKE,
    ST_FIRE,
    ST_WAIT
  } seq_state_e;

  // One-hot select of a task index
  function automatic logic [TASK_N-1:0] task_onehot(input logic [TASK_IW-1:0] idx);
    logic [TASK_N-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // True for the final link of the chain
  function automatic logic is_last(input logic [TASK_IW-1:0] idx);
    return idx == IDX_ACK;
  endfunction

  // Tasks from sensing through sending need the measurement memory
  function automatic logic uses_gated_mem(input logic [TASK_IW-1:0] idx);
    return idx <= IDX_SEND;
  endfunction

  // Successor in the chain
  function automatic logic [TASK_IW-1:0] next_idx(input logic [TASK_IW-1:0] idx);
    return idx + TASK_IW'(1);
  endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int PERIOD_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);
  assign tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  initial begin
    if (PERIOD_CYC < 2) $error("PERIOD_CYC must be at least 2");
  end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import mtask_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 radio_evt,
  input  logic [TASK_N-1:0]    task_done,
  output seq_state_e           state,
  output logic [TASK_IW-1:0]   idx
);
  seq_state_e         state_q, state_d;
  logic [TASK_IW-1:0] idx_q, idx_d;
  logic               pend_q, pend_d;

  // Named internal events
  logic idle;
  logic ev_launch_timer;
  logic ev_launch_radio;
  logic ev_step;
  logic ev_finish;

  assign idle            = (state_q == ST_IDLE);
  assign ev_launch_timer = idle && (tick || pend_q);
  assign ev_launch_radio = idle && !ev_launch_timer && radio_evt;
  assign ev_step         = (state_q == ST_WAIT) && task_done[idx_q];
  assign ev_finish       = ev_step && is_last(idx_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_launch_timer) begin
          state_d = ST_WAKE;
          idx_d   = IDX_SENSE;
          pend_d  = 1'b0;
        end else if (ev_launch_radio) begin
          state_d = ST_WAKE;
          idx_d   = IDX_ACK;
        end
      end
      ST_WAKE: state_d = ST_FIRE;
      ST_FIRE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (ev_finish) begin
          state_d = ST_IDLE;
        end else if (ev_step) begin
          state_d = ST_WAKE;
          idx_d   = next_idx(idx_q);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!idle && tick) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
    end
  end

  assign state = state_q;
  assign idx   = idx_q;

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !idle) |=> pend_q);

  // R8
  pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pend_q) |=> (state_q == ST_WAKE && idx_q == IDX_SENSE));

  // R2
  chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && !ev_finish) |=> (state_q == ST_WAKE && idx_q == $past(idx_q) + TASK_IW'(1)));

  // R10
  radio_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && radio_evt && !ev_step) |=> (idx_q == $past(idx_q)));

  // R9
  radio_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch_radio |=> (idx_q == IDX_ACK && state_q == ST_WAKE));
endmodule

// File: rtl/domain_map.sv
module domain_map
  import mtask_seq_pkg::*;
(
  input  seq_state_e           state,
  input  logic [TASK_IW-1:0]   idx,
  output logic [TASK_N-1:0]    task_pwr,
  output logic [TASK_N-1:0]    task_go,
  output logic                 gmem_pwr,
  output logic                 amem_pwr
);
  logic active;
  logic [TASK_N-1:0] sel;

  assign active   = (state != ST_IDLE);
  assign sel      = task_onehot(idx);
  assign task_pwr = active ? sel : '0;
  assign task_go  = (state == ST_FIRE) ? sel : '0;
  assign gmem_pwr = active && uses_gated_mem(idx);
  assign amem_pwr = 1'b1;
endmodule

// File: rtl/mtask_seq.sv
module mtask_seq
  import mtask_seq_pkg::*;
#(
  parameter int PERIOD_CYC = 5_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] task_done,
  input  logic       radio_evt,
  output logic [3:0] task_pwr,
  output logic [3:0] task_go,
  output logic       gmem_pwr,
  output logic       amem_pwr
);
  logic               tick;
  seq_state_e         state;
  logic [TASK_IW-1:0] idx;

  tick_gen #(.PERIOD_CYC(PERIOD_CYC)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  chain_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .radio_evt (radio_evt),
    .task_done (task_done),
    .state     (state),
    .idx       (idx)
  );

  domain_map map_i (
    .state    (state),
    .idx      (idx),
    .task_pwr (task_pwr),
    .task_go  (task_go),
    .gmem_pwr (gmem_pwr),
    .amem_pwr (amem_pwr)
  );

  // R4
  pwr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(task_pwr));

  // R3
  go_inside_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|task_go) |-> ((task_go & task_pwr) == task_go));

  // R3
  go_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|task_go) |-> ($past(task_pwr) == task_pwr && $past(task_go) == '0));

  // R6
  gmem_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmem_pwr == (|task_pwr[2:0]));

  // R3 R5: a task loses power only after its own completion line was high
  for (genvar k = 0; k < TASK_N; k++) begin : g_drop
    pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(task_pwr[k]) |-> $past(task_done[k]));
  end
endmodule

// File: tb/mtask_seq_tb_top.sv
`timescale 1ns/1ps
module mtask_seq_tb_top;
  localparam int P = 60;

  // Vector table: task index and wait cycles before its completion
  localparam int N_ROW = 8;
  localparam int TAB_IDX [N_ROW] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int TAB_DLY [N_ROW] = '{0, 1, 2, 3, 2, 0, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] task_done = '0;
  logic       radio_evt = 1'b0;
  logic [3:0] task_pwr, task_go;
  logic       gmem_pwr, amem_pwr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int start_a = -1;
  int start_b = -1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mtask_seq #(.PERIOD_CYC(P)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .task_done (task_done),
    .radio_evt (radio_evt),
    .task_pwr  (task_pwr),
    .task_go   (task_go),
    .gmem_pwr  (gmem_pwr),
    .amem_pwr  (amem_pwr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int want_gmem(input int idx);
    return (idx < 3) ? 1 : 0;
  endfunction

  // Runs one task; bench sits at a negedge on entry and on exit
  task automatic run_step(input int idx, input int dly, input bit poll, input bit mess);
    int oh;
    oh = 1 << idx;
    if (poll) begin
      for (int w = 0; w < 3 * P && task_pwr == 0; w++) @(negedge clk);
      chk("R1", "chain start seen", int'(task_pwr != 0), 1);
    end
    if (idx == 0) begin
      start_a = start_b;
      start_b = cyc;
    end
    chk("R2", "wake power", task_pwr, oh);
    chk("R3", "no start during wake", task_go, 0);
    chk("R6", "gated mem at wake", gmem_pwr, want_gmem(idx));
    @(negedge clk);
    chk("R3", "start pulse", task_go, oh);
    chk("R3", "power with start", task_pwr, oh);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R3", "start is one cycle", task_go, 0);
      chk("R5 R10", "power held while waiting", task_pwr, oh);
      chk("R6", "gated mem while waiting", gmem_pwr, want_gmem(idx));
      if (mess && i == 0) begin
        task_done = 4'hF & ~oh[3:0];
        radio_evt = 1'b1;
      end
      if (mess && i == 1) begin
        task_done = '0;
        radio_evt = 1'b0;
      end
    end
    @(negedge clk);
    chk("R3", "power before completion", task_pwr, oh);
    task_done = oh[3:0];
    @(negedge clk);
    task_done = '0;
    if (idx == 3) begin
      chk("R4", "all off after acknowledge", task_pwr, 0);
      chk("R6", "gated mem off after chain", gmem_pwr, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "power in reset", task_pwr, 0);
    chk("R11", "start in reset", task_go, 0);
    chk("R11", "gated mem in reset", gmem_pwr, 0);
    chk("R7", "always-on mem in reset", amem_pwr, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "power after reset", task_pwr, 0);

    // Vector table walk: two timer-driven chains
    for (int r = 0; r < N_ROW; r++) begin
      run_step(TAB_IDX[r], TAB_DLY[r], TAB_IDX[r] == 0, 1'b0);
      if (r == 4) chk("R1", "period between chains", start_b - start_a, P);
    end
    chk("R7", "always-on mem while running", amem_pwr, 1);

    // R4 idle gap, then R9 radio start
    repeat (2) @(negedge clk);
    chk("R4", "idle between chains", task_pwr, 0);
    radio_evt = 1'b1;
    @(negedge clk);
    radio_evt = 1'b0;
    chk("R9", "radio wakes acknowledge only", task_pwr, 8);
    chk("R9", "gated mem off for radio start", gmem_pwr, 0);
    run_step(3, 1, 1'b0, 1'b0);

    // Long chain with stray inputs; timer event arrives while busy (R8)
    run_step(0, 25, 1'b1, 1'b0);
    chk("R1", "period kept after radio chain", start_b - start_a, P);
    run_step(1, 25, 1'b0, 1'b1);
    run_step(2, 25, 1'b0, 1'b0);
    run_step(3, 0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8", "pending event restarts chain", task_pwr, 1);
    run_step(0, 0, 1'b0, 1'b0);
    run_step(1, 0, 1'b0, 1'b0);
    run_step(2, 0, 1'b0, 1'b0);
    run_step(3, 0, 1'b0, 1'b0);

    // R11 reset in the middle of a task
    for (int w = 0; w < 3 * P && task_pwr == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6", "gated mem on during sensing", gmem_pwr, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "power cut by reset", task_pwr, 0);
    chk("R11", "gated mem cut by reset", gmem_pwr, 0);
    chk("R7", "always-on mem during reset", amem_pwr, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "no pending after reset", task_pwr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule